// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the host side of a link to a serial 8-bit successive-approximation converter that waits for a start bit. When a request is accepted it pulls chip select low and makes a serial clock from the system clock through a divider. On the data-in line it sends a chosen number of zeros, then a single 1 as the start bit, then an address word that gives the input mode, the polarity and the channel. After the address it lets go of the line, drops the converter's single leading-zero bit and shifts in the eight result bits, most significant first.

If the request asks for it, the block also takes in the eight-bit replay that the converter sends least significant first after the conversion. It compares that replay, with its bits reversed, against the first copy of the result. When the frame ends it raises chip select, gives a one-cycle done pulse with the result and a mismatch flag, and keeps chip select high for at least one serial clock period before it will accept the next request.

Top module: `adc_sreader`

## Requirements
- R1: During and straight after reset, chip select is high, the serial clock is low, the data-in drive enable is low, the done pulse is low and the request ready is high.
- R2: A request is accepted in a cycle where valid and ready are both high, and chip select falls on the next clock edge. Whenever chip select is high the serial clock is low.
- R3: Let h be div_i + 1, where a div_i of 0 counts as 1. The value is latched when the request is accepted. The first rising serial clock edge comes h system cycles after chip select falls, and each later rising edge comes 2h cycles after the one before it.
- R4: At the rising serial clock edges, data-in carries lead_zeros_i zeros, then a 1, then the address. The address is sent most significant bit first: mode bit (1 = single-ended), polarity bit, then the ADDR_W-2 low bits of the channel.
- R5: The data-in drive enable is high from the fall of chip select until the falling serial clock edge that ends the last address bit. It is low after that.
- R6: The data-out bit sampled in the clock period right after the address is thrown away. Its value has no effect on the result.
- R7: The eight data-out bits sampled in the next eight periods form res_data_o, with the first sampled bit as bit 7.
- R8: When replay is requested, eight more periods are sampled, with the first one taken as bit 0. res_mismatch_o is 1 exactly when this word differs from the result. Without replay, res_mismatch_o is 0.
- R9: A frame has lead_zeros_i + ADDR_W + 10 rising serial clock edges, plus 8 more with replay. Chip select rises on the falling edge that ends the last period. res_valid_o is high for exactly that one cycle.
- R10: req_ready_o is low while chip select is low. Chip select stays high for at least 2h system cycles before it falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| lead_zeros_i | input | 2 | Number of zeros sent before the start bit |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_se_i | input | 1 | Mode bit: 1 single-ended, 0 differential |
| req_odd_i | input | 1 | Polarity bit |
| req_chan_i | input | CH_W | Channel select |
| req_replay_i | input | 1 | Capture and check the LSB-first replay |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_no | output | 1 | Chip select, active low |
| sdo_o | output | 1 | Data toward the converter's data-in |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| sdi_i | input | 1 | Converter data-out |
| res_valid_o | output | 1 | One-cycle done pulse |
| res_data_o | output | 8 | Conversion result |
| res_mismatch_o | output | 1 | Replay did not match the result |

## Verification
The done pulse and a waiting request can land in the same cycle. The bench starts the next request as soon as the previous one is accepted and keeps its valid high through the end of that frame. That request must not be taken in the done cycle, so the chip-select high time is measured against the previous frame's divider. The result of the earlier frame, and the address and edge count of the later one, are then checked against what was queued.

// File: rtl/adc_sr_pkg.sv
package adc_sr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} st_e;
  localparam int unsigned RES_W  = 8;
  localparam int unsigned MAX_LZ = 3;
endpackage

// File: rtl/adc_sr_clkgen.sv
module adc_sr_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_m1_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt;
  logic             ph;
  logic             wrap;

  assign wrap = (cnt == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run_i) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sclk_o = ph;
  assign rise_o = run_i & ~ph & wrap;
  assign fall_o = run_i &  ph & wrap;
endmodule

// File: rtl/adc_sr_txsel.sv
module adc_sr_txsel #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned CH_W  = (ADDR_W > 2) ? ADDR_W - 2 : 1,
  localparam int unsigned OFF_W = (ADDR_W > 2) ? $clog2(ADDR_W) : 1
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] start_slot_i,
  input  logic [SLOT_W-1:0] last_addr_i,
  input  logic              se_i,
  input  logic              odd_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              bit_o
);
  logic [ADDR_W-1:0] word;
  logic [SLOT_W-1:0] off;

  generate
    if (ADDR_W > 2) begin : g_chan
      assign word = {se_i, odd_i, chan_i[ADDR_W-3:0]};
    end else begin : g_nochan
      assign word = {se_i, odd_i};
    end
  endgenerate

  assign off = last_addr_i - slot_i;

  always_comb begin
    if (slot_i < start_slot_i)       bit_o = 1'b0;
    else if (slot_i == start_slot_i) bit_o = 1'b1;
    else if (slot_i <= last_addr_i)  bit_o = word[off[OFF_W-1:0]];
    else                             bit_o = 1'b0;
  end
endmodule

// File: rtl/adc_sr_rxcap.sv
module adc_sr_rxcap #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned RES_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] first_i,
  input  logic              sdi_i,
  output logic [RES_W-1:0]  msb_o,
  output logic [RES_W-1:0]  lsb_o
);
  logic [SLOT_W-1:0] off;
  assign off = slot_i - first_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_o <= '0;
      lsb_o <= '0;
    end else if (clr_i) begin
      msb_o <= '0;
      lsb_o <= '0;
    end else if (rise_i && slot_i >= first_i) begin
      if (off < SLOT_W'(RES_W))
        msb_o <= {msb_o[RES_W-2:0], sdi_i};
      else if (off < SLOT_W'(2*RES_W))
        lsb_o <= {sdi_i, lsb_o[RES_W-1:1]};  // first replay bit lands in bit 0
    end
  end
endmodule

// File: rtl/adc_sreader.sv
module adc_sreader
  import adc_sr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned CH_W  = (ADDR_W > 2) ? ADDR_W - 2 : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       lead_zeros_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_se_i,
  input  logic             req_odd_i,
  input  logic [CH_W-1:0]  req_chan_i,
  input  logic             req_replay_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic             sdi_i,
  output logic             res_valid_o,
  output logic [7:0]       res_data_o,
  output logic             res_mismatch_o
);
  localparam int unsigned MAX_SLOTS = MAX_LZ + 1 + ADDR_W + 1 + 2*RES_W;
  localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS + 1);

  st_e               st;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        z_q;
  logic              se_q, odd_q, rep_q;
  logic [CH_W-1:0]   chan_q;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W:0]    gap;
  logic              res_valid;
  logic [RES_W-1:0]  res_data;
  logic              res_mis;

  logic              run, rise, fall, accept, tx_bit;
  logic [SLOT_W-1:0] start_slot, last_addr, first_res, last_slot;
  logic [RES_W-1:0]  msb_w, lsb_w;

  assign run        = (st == ST_RUN);
  assign accept     = (st == ST_IDLE) && req_valid_i;
  assign start_slot = SLOT_W'(z_q);
  assign last_addr  = start_slot + SLOT_W'(ADDR_W);
  assign first_res  = last_addr + SLOT_W'(2);
  assign last_slot  = last_addr + (rep_q ? SLOT_W'(2*RES_W + 1) : SLOT_W'(RES_W + 1));

  adc_sr_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .run_i(run), .half_m1_i(div_q),
    .sclk_o, .rise_o(rise), .fall_o(fall)
  );

  adc_sr_txsel #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_tx (
    .slot_i(slot), .start_slot_i(start_slot), .last_addr_i(last_addr),
    .se_i(se_q), .odd_i(odd_q), .chan_i(chan_q), .bit_o(tx_bit)
  );

  adc_sr_rxcap #(.SLOT_W(SLOT_W), .RES_W(RES_W)) u_rx (
    .clk_i, .rst_ni, .clr_i(accept), .rise_i(rise), .slot_i(slot),
    .first_i(first_res), .sdi_i, .msb_o(msb_w), .lsb_o(lsb_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      slot      <= '0;
      z_q       <= '0;
      se_q      <= 1'b0;
      odd_q     <= 1'b0;
      rep_q     <= 1'b0;
      chan_q    <= '0;
      div_q     <= DIV_W'(1);
      gap       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_mis   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_RUN;
          slot   <= '0;
          z_q    <= lead_zeros_i;
          se_q   <= req_se_i;
          odd_q  <= req_odd_i;
          chan_q <= req_chan_i;
          rep_q  <= req_replay_i;
          div_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
        end
        ST_RUN: if (fall) begin
          if (slot == last_slot) begin
            st        <= ST_GAP;
            gap       <= {div_q, 1'b1};  // 2h-1 more cycles of chip select high
            res_valid <= 1'b1;
            res_data  <= msb_w;
            res_mis   <= rep_q && (lsb_w != msb_w);
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_GAP: if (gap == '0) st <= ST_IDLE;
                else           gap <= gap - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (st == ST_IDLE);
  assign cs_no          = ~run;
  assign sdo_oe_o       = run && (slot <= last_addr);
  assign sdo_o          = sdo_oe_o & tx_bit;
  assign res_valid_o    = res_valid;
  assign res_data_o     = res_data;
  assign res_mismatch_o = res_mis;
endmodule

// File: rtl/adc_sreader_chk.sv
module adc_sreader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic sdo_oe_o,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic res_valid_o
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);  // R2
  AST_CS_FALL_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> $fell(cs_no));  // R2
  AST_OE_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !cs_no);  // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);  // R9
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $rose(cs_no));  // R9
  AST_NO_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);  // R10
endmodule

bind adc_sreader adc_sreader_chk u_chk (.*);

// File: tb/tb_adc_sreader.sv
`timescale 1ns/1ps
module tb_adc_sreader;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 8;

  typedef struct {
    logic [7:0] val;
    bit junk, cor, rep;
    int z, half;
    logic [3:0] addr;
    bit mis;
  } item_t;

  logic clk_i = 0, rst_ni = 0;
  logic [DIV_W-1:0] div_i = 1;
  logic [1:0] lead_zeros_i = 0;
  logic req_valid_i = 0, req_se_i = 0, req_odd_i = 0, req_replay_i = 0;
  logic [1:0] req_chan_i = 0;
  logic req_ready_o, sclk_o, cs_no, sdo_o, sdo_oe_o, res_valid_o, res_mismatch_o;
  logic [7:0] res_data_o;
  logic sdi = 0;

  adc_sreader #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) dut (
    .clk_i, .rst_ni, .div_i, .lead_zeros_i, .req_valid_i, .req_ready_o,
    .req_se_i, .req_odd_i, .req_chan_i, .req_replay_i, .sclk_o, .cs_no,
    .sdo_o, .sdo_oe_o, .sdi_i(sdi), .res_valid_o, .res_data_o, .res_mismatch_o
  );

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  item_t dev_q[$], exp_q[$];

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // converter model
  item_t d;
  int rcnt = 0, zc = 0, ab = 0, post = 0;
  bit started = 0, oe_err = 0;
  logic [3:0] ag = 0;
  int cur_half = 0, prev_half = 0;

  always @(negedge cs_no) begin
    if (dev_q.size() > 0) d = dev_q.pop_front();
    rcnt = 0; zc = 0; ab = 0; post = 0; started = 0; oe_err = 0; ag = 0; sdi = 0;
  end

  always @(posedge sclk_o) if (!cs_no) begin
    rcnt++;
    if (!started || ab < ADDR_W) begin
      if (!sdo_oe_o) oe_err = 1;
      if (!started) begin
        if (sdo_o) started = 1; else zc++;
      end else begin
        ag = {ag[2:0], sdo_o};
        ab++;
      end
    end else if (sdo_oe_o) oe_err = 1;
  end

  always @(negedge sclk_o) if (!cs_no && started && ab == ADDR_W) begin
    post++;
    if (post == 1) sdi = d.junk;
    else if (post <= 9) sdi = d.val[9-post];
    else if (post <= 17) sdi = d.val[post-10] ^ (d.cor && post == 13);
    else sdi = 0;
  end

  // timing observer and scoreboard monitor
  int cyc = 0, last_rise = 0, cs_fall_cyc = 0, cs_rise_cyc = -1;
  int e_idle = 0, e_per = 0, e_busy = 0, e_gap = 0;
  bit first_rise = 0, prev_sclk = 0, prev_cs = 1, prev_valid = 0;

  always @(negedge clk_i) if (rst_ni) begin
    item_t it;
    cyc++;
    if (prev_cs && !cs_no) begin
      prev_half = cur_half;
      cur_half = d.half;
      if (cs_rise_cyc >= 0 && cyc - cs_rise_cyc < 2*prev_half) e_gap++;
      cs_fall_cyc = cyc;
      first_rise = 1;
    end
    if (!prev_cs && cs_no) cs_rise_cyc = cyc;
    if (cs_no && sclk_o) e_idle++;
    if (!cs_no && req_ready_o) e_busy++;
    if (sclk_o && !prev_sclk) begin
      if (first_rise) begin
        if (cyc - cs_fall_cyc != cur_half) e_per++;
        first_rise = 0;
      end else if (cyc - last_rise != 2*cur_half) e_per++;
      last_rise = cyc;
    end
    if (prev_valid) chk("R9 done pulse width", res_valid_o, 0);
    if (res_valid_o) begin
      if (exp_q.size() == 0) chk("R9 unexpected done", 1, 0);
      else begin
        it = exp_q.pop_front();
        chk(it.junk ? "R6/R7 result with junk leading bit" : "R7 result", res_data_o, it.val);
        chk("R8 mismatch flag", res_mismatch_o, it.mis);
        chk("R4 leading zeros", zc, it.z);
        chk("R4 address word", ag, it.addr);
        chk("R9 rising edge count", rcnt, it.z + ADDR_W + 10 + (it.rep ? 8 : 0));
        chk("R9 cs high at done", cs_no, 1);
        chk("R5 drive enable window", oe_err, 0);
        chk("R3 serial clock timing", e_per, 0);
        chk("R2 sclk low while deselected", e_idle, 0);
        chk("R10 ready low while busy", e_busy, 0);
        chk("R10 chip select high gap", e_gap, 0);
        e_per = 0; e_idle = 0; e_busy = 0; e_gap = 0;
      end
    end
    prev_valid = res_valid_o;
    prev_sclk = sclk_o;
    prev_cs = cs_no;
  end

  // driver
  task automatic issue(int z, bit se, bit odd, int ch, bit rep, int dv,
                       logic [7:0] val, bit junk, bit cor);
    item_t it;
    it.val = val; it.junk = junk; it.cor = cor; it.rep = rep; it.z = z;
    it.half = ((dv == 0) ? 1 : dv) + 1;
    it.addr = {se, odd, 2'(ch)};
    it.mis = rep && cor;
    dev_q.push_back(it);
    exp_q.push_back(it);
    @(negedge clk_i);
    div_i = DIV_W'(dv); lead_zeros_i = 2'(z); req_se_i = se; req_odd_i = odd;
    req_chan_i = 2'(ch); req_replay_i = rep; req_valid_i = 1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 cs_n reset", cs_no, 1);
    chk("R1 sclk reset", sclk_o, 0);
    chk("R1 oe reset", sdo_oe_o, 0);
    chk("R1 done reset", res_valid_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 ready after reset", req_ready_o, 1);

    issue(0, 1, 0, 2, 0, 1, 8'hA5, 1, 0); drain();
    issue(3, 0, 1, 1, 1, 3, 8'h3C, 0, 0); drain();
    issue(1, 1, 1, 3, 1, 2, 8'h81, 1, 1); drain();   // R8 corrupted replay
    issue(2, 0, 0, 0, 0, 0, 8'h00, 1, 0); drain();   // R3 div 0 acts as 1
    issue(0, 1, 0, 1, 1, 1, 8'hFF, 0, 0); drain();
    issue(2, 0, 1, 2, 0, 1, 8'h5A, 1, 1); drain();   // R8 no replay, no flag
    // back-to-back: second request waits across the done pulse
    issue(1, 1, 0, 3, 1, 4, 8'h96, 1, 0);
    issue(3, 0, 0, 1, 0, 1, 8'h69, 0, 0);
    issue(0, 1, 1, 0, 1, 2, 8'hC3, 1, 1);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL R9 watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule